// File: doc/BRIEF.md
# Unaligned Receive Buffer Writer

This block turns a stream of received frame bytes into 32-bit word writes to a receive buffer in memory. The buffer can start at any byte address. Each write goes to a word-aligned address and carries a four-bit byte strobe. Only the lanes that hold frame data are strobed. Lanes below the start address in the first word, and lanes past the last byte in the final word, carry a dummy byte with their strobe low. A byte outside the buffer is therefore never modified.

A buffer is handed over as a start address and a programmed size; the size is a multiple of four. The usable room is the size minus the two low address bits. When that room is used up in the middle of a frame, the block closes the buffer, takes the next one and carries on with the same frame. An end of frame always closes the buffer, even if space is left, so every frame starts on a fresh buffer.

When a buffer closes, the block reports a status. The status says whether the buffer holds the start of the frame and whether it holds the end of the frame. It also gives the number of frame bytes written so far, so software can work out how much space is left unused. Reading and writing descriptors, and the receive MAC, are outside this block.

Top module: `rxWordPacker`

## Requirements
- R1: Every write address has its low two bits at 0. The first write for a buffer goes to the buffer address with its low two bits cleared, and each later write for that buffer goes to the previous address plus 4.
- R2: Strobe bit b (b = 0..3) enables byte wrData[8b+7:8b] at address wrAddr+b. A strobe is high only on a lane that carries a frame byte. Every unstrobed lane carries the dummy byte 8'h00. Every write strobes at least one lane.
- R3: A buffer that receives n bytes at start offset lo (the address's low two bits) gets exactly (lo+n+3)/4 writes, rounded down. For example, 16 bytes at offset 2 give five writes, with strobes 4'b1100, 4'b1111, 4'b1111, 4'b1111 and 4'b0011.
- R4: A buffer takes at most size − lo bytes. When that many bytes have been written, the buffer closes. No memory byte outside [address, address+size−lo) is modified.
- R5: doneFirst is 1 exactly for the buffer that received the byte marked inSof.
- R6: doneLast is 1 exactly for the buffer that received the byte marked inEof. If the frame fits, one status has both doneFirst and doneLast set.
- R7: doneLen is the number of frame bytes accepted from the start of the frame up to the end of the buffer being closed.
- R8: inEof closes the buffer even if room is left, so the next frame starts on a new buffer. inReady is 0 in the cycle that the status is reported.
- R9: A partly filled word is written in the same cycle that the status of its buffer is reported (doneValid implies wrValid).
- R10: No byte is accepted without a buffer. inReady is 0 during reset, is 0 while no buffer has been taken, and is 0 in the cycle bufTake is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bufValid | input | 1 | A next buffer is available |
| bufAddr | input | ADDR_W | Start byte address of the offered buffer |
| bufSize | input | SIZE_W | Programmed size in bytes, a multiple of four and at least 4 |
| bufTake | output | 1 | The offered buffer is taken in this cycle |
| inValid | input | 1 | Received byte present |
| inData | input | 8 | Received byte |
| inSof | input | 1 | Byte is the first of its frame |
| inEof | input | 1 | Byte is the last of its frame |
| inReady | output | 1 | Byte is accepted at the next edge when inValid is 1 |
| wrValid | output | 1 | Word write present; the memory always accepts it |
| wrAddr | output | ADDR_W | Word-aligned write address |
| wrData | output | 32 | Write data, lane b in bits 8b+7:8b |
| wrStrb | output | 4 | Byte strobes, bit b for lane b |
| doneValid | output | 1 | Current buffer closed, status valid |
| doneFirst | output | 1 | Closed buffer holds the start of the frame |
| doneLast | output | 1 | Closed buffer holds the end of the frame |
| doneLen | output | LEN_W | Frame bytes up to the end of the closed buffer |

## Verification
The assertions assume that the input is well formed:
- Every frame begins with a byte marked inSof and ends with a byte marked inEof.
- Each inSof follows the previous frame's inEof.
- Every offered size is at least 4 and a multiple of four.

The bench drives only such frames and sizes. It offers a fresh buffer whenever one is taken, with each buffer in its own region of a memory model, so that any write outside a buffer shows up in a full compare of the memory. The sweep covers every start offset, several sizes and frame lengths from one byte up to several buffers. It also includes a short frame followed by a second frame and a stretch with no buffer offered.

// File: rtl/rxPackPkg.sv
package rxPackPkg;
  typedef struct packed {
    logic loadBuf;   // latch a new buffer
    logic takeByte;  // accept one byte into the current word
    logic emitWord;  // write the current word out with this byte
  } packCtl_t;
endpackage

// File: rtl/rxPackDatapath.sv
module rxPackDatapath
  import rxPackPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [7:0] DUMMY = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  packCtl_t          ctl,
  input  logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        inData,
  output logic              laneLast,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrStrb
);
  localparam int LANES = 4;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES);

  logic [1:0]        laneQ;
  logic [ADDR_W-1:0] wordAddrQ;
  logic [31:0]       accQ, accNext;
  logic [3:0]        strbQ, strbNext;

  assign laneLast = (laneQ == 2'd3);

  always_comb begin
    accNext  = accQ;
    strbNext = strbQ;
    for (int b = 0; b < LANES; b++) begin
      if (laneQ == b[1:0]) begin
        accNext[8*b +: 8] = inData;
        strbNext[b]       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ     <= '0;
      wordAddrQ <= '0;
      accQ      <= {LANES{DUMMY}};
      strbQ     <= '0;
      wrValid   <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      wrStrb    <= '0;
    end else begin
      wrValid <= 1'b0;
      if (ctl.loadBuf) begin
        laneQ     <= bufAddr[1:0];
        wordAddrQ <= {bufAddr[ADDR_W-1:2], 2'b00};
        accQ      <= {LANES{DUMMY}};
        strbQ     <= '0;
      end else if (ctl.takeByte) begin
        if (ctl.emitWord) begin
          wrValid   <= 1'b1;
          wrAddr    <= wordAddrQ;
          wrData    <= accNext;
          wrStrb    <= strbNext;
          accQ      <= {LANES{DUMMY}};
          strbQ     <= '0;
          laneQ     <= '0;
          wordAddrQ <= wordAddrQ + STEP;
        end else begin
          accQ  <= accNext;
          strbQ <= strbNext;
          laneQ <= laneQ + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rxPackCtrl.sv
module rxPackCtrl
  import rxPackPkg::*;
#(
  parameter int SIZE_W = 13,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufValid,
  input  logic [1:0]        bufOffset,
  input  logic [SIZE_W-1:0] bufSize,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic              laneLast,
  output packCtl_t          ctl,
  output logic              bufTake,
  output logic              inReady,
  output logic              doneValid,
  output logic              doneFirst,
  output logic              doneLast,
  output logic [LEN_W-1:0]  doneLen
);
  logic              openQ;
  logic [SIZE_W-1:0] roomQ;
  logic              segFirstQ;
  logic [LEN_W-1:0]  frameLenQ, lenNext;
  logic              lastRoom, closeNow;

  always_comb begin
    ctl.loadBuf  = !openQ && bufValid;
    ctl.takeByte = openQ && inValid;
    lastRoom     = (roomQ == SIZE_W'(1));
    closeNow     = ctl.takeByte && (inEof || lastRoom);
    ctl.emitWord = ctl.takeByte && (laneLast || inEof || lastRoom);
    lenNext      = inSof ? LEN_W'(1) : frameLenQ + LEN_W'(1);
  end

  assign bufTake = ctl.loadBuf;
  assign inReady = openQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ     <= 1'b0;
      roomQ     <= '0;
      segFirstQ <= 1'b0;
      frameLenQ <= '0;
      doneValid <= 1'b0;
      doneFirst <= 1'b0;
      doneLast  <= 1'b0;
      doneLen   <= '0;
    end else begin
      doneValid <= 1'b0;
      if (ctl.loadBuf) begin
        openQ     <= 1'b1;
        roomQ     <= bufSize - {{(SIZE_W-2){1'b0}}, bufOffset};
        segFirstQ <= 1'b0;
      end
      if (ctl.takeByte) begin
        roomQ     <= roomQ - SIZE_W'(1);
        frameLenQ <= lenNext;
        if (inSof) segFirstQ <= 1'b1;
      end
      if (closeNow) begin
        openQ     <= 1'b0;
        doneValid <= 1'b1;
        doneFirst <= segFirstQ || inSof;
        doneLast  <= inEof;
        doneLen   <= lenNext;
      end
    end
  end
endmodule

// File: rtl/rxWordPacker.sv
module rxWordPacker
  import rxPackPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13,
  parameter int LEN_W  = 14,
  parameter logic [7:0] DUMMY = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufValid,
  input  logic [ADDR_W-1:0] bufAddr,
  input  logic [SIZE_W-1:0] bufSize,
  output logic              bufTake,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inSof,
  input  logic              inEof,
  output logic              inReady,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrStrb,
  output logic              doneValid,
  output logic              doneFirst,
  output logic              doneLast,
  output logic [LEN_W-1:0]  doneLen
);
  packCtl_t ctl;
  logic     laneLast;

  rxPackCtrl #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bufValid(bufValid), .bufOffset(bufAddr[1:0]),
    .bufSize(bufSize), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .laneLast(laneLast), .ctl(ctl), .bufTake(bufTake), .inReady(inReady),
    .doneValid(doneValid), .doneFirst(doneFirst), .doneLast(doneLast),
    .doneLen(doneLen)
  );

  rxPackDatapath #(.ADDR_W(ADDR_W), .DUMMY(DUMMY)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bufAddr(bufAddr), .inData(inData),
    .laneLast(laneLast), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrStrb(wrStrb)
  );
endmodule

// File: rtl/rxWordPackerChk.sv
module rxWordPackerChk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              bufTake,
  input logic              inReady,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [3:0]        wrStrb,
  input logic              doneValid,
  input logic [LEN_W-1:0]  doneLen
);
  // R1
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr[1:0] == 2'b00));

  // R2
  strobe_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ($countones(wrStrb) >= 1));

  // R9
  flush_with_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> wrValid);

  // R8
  closed_after_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !inReady);

  // R10
  no_intake_on_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufTake |-> !inReady);

  // R10
  open_follows_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(bufTake));

  // R7
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneLen != '0));
endmodule

bind rxWordPacker rxWordPackerChk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .bufTake(bufTake), .inReady(inReady),
  .wrValid(wrValid), .wrAddr(wrAddr), .wrStrb(wrStrb),
  .doneValid(doneValid), .doneLen(doneLen)
);

// File: tb/tb_rxWordPacker.sv
`timescale 1ns/1ps
module tb_rxWordPacker;
  localparam int AW = 32;
  localparam int SW = 13;
  localparam int LW = 14;
  localparam int MEMSZ = 1024;
  localparam int REGION = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          bufEn = 1'b0;
  logic          bufValid, bufTake;
  logic [AW-1:0] bufAddr;
  logic [SW-1:0] bufSize;
  logic          inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inReady;
  logic [7:0]    inData = 8'h00;
  logic          wrValid, doneValid, doneFirst, doneLast;
  logic [AW-1:0] wrAddr;
  logic [31:0]   wrData;
  logic [3:0]    wrStrb;
  logic [LW-1:0] doneLen;

  int bufIdx, lo, sizeV;
  assign bufValid = bufEn;
  assign bufAddr  = AW'(REGION * bufIdx + lo);
  assign bufSize  = SW'(sizeV);

  rxWordPacker dut (
    .clk(clk), .rstN(rstN), .bufValid(bufValid), .bufAddr(bufAddr),
    .bufSize(bufSize), .bufTake(bufTake), .inValid(inValid), .inData(inData),
    .inSof(inSof), .inEof(inEof), .inReady(inReady), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb), .doneValid(doneValid),
    .doneFirst(doneFirst), .doneLast(doneLast), .doneLen(doneLen)
  );

  always @(posedge clk) begin
    if (!rstN) bufIdx <= 0;
    else if (bufTake) bufIdx <= bufIdx + 1;
  end

  int nChk = 0, nBad = 0, cycles = 0;
  logic [7:0] mem [MEMSZ];
  logic [7:0] expMem [MEMSZ];
  int wrCnt, doneCnt, alignBad, dummyBad, flushBad;
  int wrPerBuf [32];
  int rFirst [32], rLast [32], rLen [32];

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      report();
      $finish;
    end
  end

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wrValid) begin
        wrCnt++;
        if (wrAddr[1:0] != 2'b00) alignBad++;
        if (wrStrb == 4'b0000) dummyBad++;
        begin
          int bi;
          bi = int'(wrAddr[9:0]) / REGION;
          if (bi < 32) wrPerBuf[bi]++;
        end
        for (int b = 0; b < 4; b++) begin
          int a;
          a = int'(wrAddr[9:0]) + b;
          if (wrStrb[b]) begin
            if (a < MEMSZ) mem[a] = wrData[8*b +: 8];
          end else if (wrData[8*b +: 8] != 8'h00) dummyBad++;
        end
      end
      if (doneValid) begin
        if (!wrValid) flushBad++;
        if (doneCnt < 32) begin
          rFirst[doneCnt] = int'(doneFirst);
          rLast[doneCnt]  = int'(doneLast);
          rLen[doneCnt]   = int'(doneLen);
        end
        doneCnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int k);
    return 8'((f * 7 + k * 13 + 3) & 8'hFF);
  endfunction

  task automatic restart(input int loV, input int szV);
    @(negedge clk);
    rstN = 1'b0; bufEn = 1'b0;
    lo = loV; sizeV = szV;
    repeat (3) @(negedge clk);
    for (int a = 0; a < MEMSZ; a++) begin mem[a] = 8'hEE; expMem[a] = 8'hEE; end
    for (int i = 0; i < 32; i++) wrPerBuf[i] = 0;
    wrCnt = 0; doneCnt = 0; alignBad = 0; dummyBad = 0; flushBad = 0;
    rstN = 1'b1;
    @(negedge clk);
    bufEn = 1'b1;
  endtask

  task automatic sendFrame(input int f, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b1; inData = pat(f, k);
      inSof = (k == 0); inEof = (k == n - 1);
      while (!inReady) @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  // expected memory and statuses for one frame starting at buffer firstBuf
  task automatic expectFrame(input int f, input int n, input int firstBuf,
                             input int recBase, output int nBufs);
    int cap, used, bi;
    cap = sizeV - lo; used = 0; bi = firstBuf; nBufs = 0;
    while (used < n) begin
      int ni;
      ni = (n - used < cap) ? n - used : cap;
      for (int j = 0; j < ni; j++) expMem[REGION * bi + lo + j] = pat(f, used + j);
      chk(wrPerBuf[bi] == (lo + ni + 3) / 4, "R3", "writes per buffer",
          wrPerBuf[bi], (lo + ni + 3) / 4);
      used += ni;
      chk(rFirst[recBase + nBufs] == ((nBufs == 0) ? 1 : 0), "R5", "first flag",
          rFirst[recBase + nBufs], (nBufs == 0) ? 1 : 0);
      chk(rLast[recBase + nBufs] == ((used == n) ? 1 : 0), "R6", "last flag",
          rLast[recBase + nBufs], (used == n) ? 1 : 0);
      chk(rLen[recBase + nBufs] == used, "R7", "status length",
          rLen[recBase + nBufs], used);
      bi++; nBufs++;
    end
  endtask

  task automatic checkMemory(input string tag);
    int bad, firstA;
    bad = 0; firstA = -1;
    for (int a = 0; a < MEMSZ; a++)
      if (mem[a] !== expMem[a]) begin bad++; if (firstA < 0) firstA = a; end
    chk(bad == 0, tag, "memory bytes differ (count)", bad, 0);
  endtask

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk(inReady == 1'b0, "R10", "inReady in reset", int'(inReady), 0);
    chk(wrValid == 1'b0, "R9", "wrValid in reset", int'(wrValid), 0);
    chk(doneValid == 1'b0, "R7", "doneValid in reset", int'(doneValid), 0);

    // no buffer offered: nothing accepted, nothing written
    restart(1, 8);
    @(negedge clk);
    bufEn = 1'b0;
    restart(1, 8);
    bufEn = 1'b0;
    inValid = 1'b1; inSof = 1'b1; inData = 8'h55;
    repeat (6) @(negedge clk);
    chk(inReady == 1'b0, "R10", "inReady without buffer", int'(inReady), 0);
    chk(wrCnt == 0, "R10", "writes without buffer", wrCnt, 0);
    inValid = 1'b0; inSof = 1'b0;

    // sweep: offset x size x frame length
    for (int l = 0; l < 4; l++) begin
      for (int s = 0; s < 3; s++) begin
        for (int n = 1; n <= 12; n++) begin
          int sz, cap, nb, nBufs;
          sz = (s == 0) ? 4 : (s == 1) ? 8 : 16;
          restart(l, sz);
          sendFrame(l * 3 + s + n, n);
          repeat (4) @(negedge clk);
          cap = sz - l;
          nb = (n + cap - 1) / cap;
          chk(doneCnt == nb, "R4", "buffers used", doneCnt, nb);
          expectFrame(l * 3 + s + n, n, 0, 0, nBufs);
          checkMemory("R4");
          chk(alignBad == 0, "R1", "misaligned writes", alignBad, 0);
          chk(dummyBad == 0, "R2", "strobe/dummy lane errors", dummyBad, 0);
          chk(flushBad == 0, "R9", "status without flush", flushBad, 0);
        end
      end
    end

    // 16 bytes at offset 2: five writes, 2 lead and 2 trail dummy lanes
    begin
      int nBufs;
      restart(2, 32);
      sendFrame(5, 16);
      repeat (4) @(negedge clk);
      chk(wrCnt == 5, "R3", "writes for 16 bytes at offset 2", wrCnt, 5);
      expectFrame(5, 16, 0, 0, nBufs);
      checkMemory("R2");
      chk(dummyBad == 0, "R2", "dummy lanes strobed", dummyBad, 0);
    end

    // short frame then next frame: must start on a new buffer
    begin
      int nA, nB;
      restart(1, 16);
      sendFrame(11, 3);
      sendFrame(12, 2);
      repeat (4) @(negedge clk);
      chk(doneCnt == 2, "R8", "statuses for two short frames", doneCnt, 2);
      expectFrame(11, 3, 0, 0, nA);
      expectFrame(12, 2, 1, 1, nB);
      checkMemory("R8");
    end

    report();
    $finish;
  end
endmodule